// File: doc/BRIEF.md
# Serial Command Packet Engine

This block sits between a byte-wide UART receiver, a byte-wide UART transmitter and a small internal register port. Incoming bytes are gathered into fixed seven-byte command frames. Each frame is checked for integrity and addressing. A frame that passes is turned into exactly one register read or write, and a seven-byte reply is streamed back. Frames aimed at another device, frames with a bad checksum and frames with an unknown operation are discarded without any reply.

A control processor uses the engine to reach the registers of a chip over a serial line. Several such chips can share one line. Each one is told apart by a three-bit strap value. Only one command is in flight at a time: the receive side stalls through its ready signal until the reply has fully left. A partial frame is thrown away when the line falls idle for too long, so the parser finds the frame boundary again on its own.

Top module: `cmd_pkt_engine`

## Requirements
- R1: A frame is seven bytes, each taken on a cycle with `rx_valid_i` and `rx_ready_o` both high, in this order: header, register address, data byte 3 (most significant), data byte 2, data byte 1, data byte 0 (least significant), checksum.
- R2: The checksum byte must equal the XOR of the six bytes before it. Otherwise the frame is dropped: no register strobe, no reply, and `rx_ready_o` stays high.
- R3: Header bits 7:5 must be 3'b010 and header bits 4:2 must equal `dev_num_i`. Otherwise the frame is dropped silently.
- R4: Header bits 1:0 select the operation: 2'b01 is a read and 2'b11 is a write. The codes 2'b00 and 2'b10 cause the frame to be dropped.
- R5: For a valid write, `reg_we_o` is high for exactly one cycle, the cycle after the checksum byte is taken. In that cycle `reg_addr_o` is the address byte and `reg_wdata_o` is data byte 0.
- R6: For a valid read, `reg_re_o` is high for exactly one cycle, the cycle after the checksum byte is taken. `reg_rdata_i` is sampled in that same cycle from the register at `reg_addr_o`.
- R7: The reply starts with `tx_valid_o` in the cycle after the strobe. It carries, in order: the command header, the address, three zero bytes, a last data byte (the read value for a read, zero for a write), and the XOR of those six bytes.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_valid_o` hold.
- R9: `rx_ready_o` is low from the cycle after a valid frame's checksum byte is taken until the last reply byte is taken.
- R10: If GAP_CYCLES consecutive cycles pass without a byte being taken while a frame is partly received, the partial frame is discarded and the next byte is taken as a header. A gap of GAP_CYCLES-1 cycles keeps the frame.
- R11: After reset, `rx_ready_o` is high, and `tx_valid_o`, `reg_we_o` and `reg_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_num_i | input | 3 | Strapped device number |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte is present |
| rx_ready_o | output | 1 | Engine can take a byte |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte is present |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, same cycle |

## Verification
The bench sends frames that are wrong in exactly one way: a foreign device number, a foreign type, op codes 00 and 10, and a corrupted checksum. A design that decoded only part of the header, or that checked the checksum loosely, would strobe a register or send a reply where none is due. Idle gaps of exactly GAP_CYCLES-1 and GAP_CYCLES cycles probe the timeout boundary. An off-by-one counter would either lose a good frame or splice a stale prefix onto the next one. Random back-pressure on the transmitter, together with read-after-write traffic, exposes reply bytes that are reordered or skipped, read data that is not captured, and write data taken from the wrong data byte.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;
  localparam int PKT_LEN = 7;
  localparam int LSB_IDX = 5;
  localparam logic [2:0] DEV_TYPE = 3'b010;

  typedef struct packed {
    logic [7:0] hdr;
    logic [7:0] addr;
    logic [7:0] lsb;
  } cmd_t;

  // bit0 high covers both legal ops (01 read, 11 write)
  function automatic logic hdr_ok(input logic [7:0] hdr, input logic [2:0] dev);
    return (hdr[7:5] == DEV_TYPE) && (hdr[4:2] == dev) && hdr[0];
  endfunction
endpackage

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx
  import cmd_pkt_pkg::*;
#(
  parameter int GAP_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] dev_num_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  input  logic       hold_i,
  output logic       cmd_valid_o,
  output cmd_t       cmd_o
);
  localparam int IDX_W = $clog2(PKT_LEN);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(GAP_CYCLES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic [7:0]       sum_q, sum_d;
  logic             valid_q;
  cmd_t             cmd_q;
  logic             accept;

  assign rx_ready_o  = !hold_i && !valid_q;
  assign accept      = rx_valid_i && rx_ready_o;
  assign sum_d       = sum_q ^ rx_data_i;
  assign cmd_valid_o = valid_q;
  assign cmd_o       = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      gap_q   <= '0;
      sum_q   <= '0;
      valid_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        gap_q <= '0;
        if (idx_q == '0) cmd_q.hdr <= rx_data_i;
        if (idx_q == IDX_W'(1)) cmd_q.addr <= rx_data_i;
        if (idx_q == IDX_W'(LSB_IDX)) cmd_q.lsb <= rx_data_i;
        if (idx_q == LAST) begin
          idx_q   <= '0;
          sum_q   <= '0;
          valid_q <= (sum_d == 8'h00) && hdr_ok(cmd_q.hdr, dev_num_i);
        end else begin
          idx_q <= idx_q + 1'b1;
          sum_q <= sum_d;
        end
      end else if (idx_q != '0) begin
        if (gap_q == GAP_LIM) begin
          idx_q <= '0;
          sum_q <= '0;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  assert_gap_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < GAP_W'(GAP_CYCLES));
endmodule

// File: rtl/cmd_pkt_exec.sv
module cmd_pkt_exec
  import cmd_pkt_pkg::*;
(
  input  logic       cmd_valid_i,
  input  cmd_t       cmd_i,
  input  logic [7:0] reg_rdata_i,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  output logic       load_o,
  output logic [7:0] rsp_lsb_o
);
  logic is_wr;
  assign is_wr       = cmd_i.hdr[1];
  assign reg_addr_o  = cmd_i.addr;
  assign reg_wdata_o = cmd_i.lsb;
  assign reg_we_o    = cmd_valid_i && is_wr;
  assign reg_re_o    = cmd_valid_i && !is_wr;
  assign load_o      = cmd_valid_i;
  assign rsp_lsb_o   = is_wr ? 8'h00 : reg_rdata_i;
endmodule

// File: rtl/cmd_pkt_tx.sv
module cmd_pkt_tx
  import cmd_pkt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] hdr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] lsb_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic       busy_o
);
  localparam int IDX_W = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic [PKT_LEN-1:0][7:0] buf_q, buf_d;
  logic [IDX_W-1:0]        idx_q;
  logic                    busy_q;

  always_comb begin
    for (int i = 0; i < PKT_LEN; i++) buf_d[i] = 8'h00;
    buf_d[0]           = hdr_i;
    buf_d[1]           = addr_i;
    buf_d[LSB_IDX]     = lsb_i;
    buf_d[PKT_LEN-1]   = hdr_i ^ addr_i ^ lsb_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      buf_q  <= buf_d;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tx_ready_i) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign tx_valid_o = busy_q;
  assign tx_data_o  = buf_q[idx_q];
  assign busy_o     = busy_q;

  assert_tx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/cmd_pkt_engine.sv
module cmd_pkt_engine
  import cmd_pkt_pkg::*;
#(
  parameter int GAP_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] dev_num_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  input  logic [7:0] reg_rdata_i
);
  cmd_t       cmd;
  logic       cmd_valid, load, busy;
  logic [7:0] rsp_lsb;

  cmd_pkt_rx #(.GAP_CYCLES(GAP_CYCLES)) u_rx (
    .clk_i, .rst_ni, .dev_num_i, .rx_data_i, .rx_valid_i, .rx_ready_o,
    .hold_i(busy), .cmd_valid_o(cmd_valid), .cmd_o(cmd)
  );

  cmd_pkt_exec u_exec (
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .reg_rdata_i,
    .reg_addr_o, .reg_wdata_o, .reg_we_o, .reg_re_o,
    .load_o(load), .rsp_lsb_o(rsp_lsb)
  );

  cmd_pkt_tx u_tx (
    .clk_i, .rst_ni, .load_i(load), .hdr_i(cmd.hdr), .addr_i(cmd.addr),
    .lsb_i(rsp_lsb), .tx_data_o, .tx_valid_o, .tx_ready_i, .busy_o(busy)
  );

  assert_strobe_reply_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |=> tx_valid_o);

  assert_own_dev_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (tx_data_o[7:5] == DEV_TYPE && tx_data_o[4:2] == dev_num_i));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !rx_ready_o);
endmodule

// File: tb/cmd_pkt_engine_test.sv
module cmd_pkt_engine_test;
  localparam int GAP = 16;
  localparam logic [2:0] DEV = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       rx_valid_i = 1'b0;
  logic       rx_ready_o;
  logic [7:0] tx_data_o;
  logic       tx_valid_o;
  logic       tx_ready_i = 1'b1;
  logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
  logic       reg_we_o, reg_re_o;

  always #2 clk = ~clk;

  cmd_pkt_engine #(.GAP_CYCLES(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dev_num_i(DEV),
    .rx_data_i, .rx_valid_i, .rx_ready_o,
    .tx_data_o, .tx_valid_o, .tx_ready_i,
    .reg_addr_o, .reg_wdata_o, .reg_we_o, .reg_re_o, .reg_rdata_i
  );

  // register file stub and bench expectation model
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i * 7 + 3);
    exp_mem[i] = 8'(i * 7 + 3);
  end
  assign reg_rdata_i = mem[reg_addr_o];

  logic [7:0] rsp_q[$];
  int we_cnt = 0, re_cnt = 0;
  logic [7:0] we_addr, we_data;
  bit rand_rdy = 1'b0;

  always @(posedge clk) begin
    if (tx_valid_o && tx_ready_i) rsp_q.push_back(tx_data_o);
    if (reg_we_o) begin
      we_cnt++; we_addr = reg_addr_o; we_data = reg_wdata_o;
      mem[reg_addr_o] = reg_wdata_o;
    end
    if (reg_re_o) re_cnt++;
  end

  always @(negedge clk) tx_ready_i <= rand_rdy ? (($urandom % 4) != 0) : 1'b1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0][7:0] mk_pkt(input logic [7:0] hdr, input logic [7:0] addr,
                                             input logic [7:0] d0, input bit bad_sum);
    logic [6:0][7:0] p;
    p[0] = hdr; p[1] = addr; p[2] = 8'($urandom); p[3] = 8'($urandom);
    p[4] = 8'($urandom); p[5] = d0;
    p[6] = p[0] ^ p[1] ^ p[2] ^ p[3] ^ p[4] ^ p[5];
    if (bad_sum) p[6] = p[6] ^ 8'h10;
    return p;
  endfunction

  function automatic logic [6:0][7:0] exp_rsp(input logic [7:0] hdr, input logic [7:0] addr,
                                              input logic [7:0] lsb);
    logic [6:0][7:0] r;
    r = '0; r[0] = hdr; r[1] = addr; r[5] = lsb; r[6] = hdr ^ addr ^ lsb;
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = b;
    do @(posedge clk); while (!rx_ready_o);
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  // gap_pos: byte index preceded by an idle gap of gap_len cycles (-1: none)
  task automatic run_cmd(input logic [6:0][7:0] p, input bit good, input int gap_pos,
                         input int gap_len, input string tag);
    int we0, re0;
    logic [7:0] lsb;
    logic [6:0][7:0] r;
    we0 = we_cnt; re0 = re_cnt;
    for (int i = 0; i < 7; i++) begin
      if (i == gap_pos) repeat (gap_len) @(posedge clk);
      send_byte(p[i]);
    end
    check(rx_ready_o == !good, {tag, " R9 ready after last byte"}, rx_ready_o, !good);
    if (good) begin
      if (p[0][1]) begin
        lsb = 8'h00; exp_mem[p[1]] = p[5];
      end else lsb = exp_mem[p[1]];
      r = exp_rsp(p[0], p[1], lsb);
      for (int k = 0; k < 300 && rsp_q.size() < 7; k++) @(negedge clk);
      check(rsp_q.size() == 7, {tag, " R7 reply length"}, rsp_q.size(), 7);
      for (int i = 0; i < 7; i++) begin
        logic [7:0] a;
        a = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'hxx;
        check(a === r[i], {tag, " R7 reply byte"}, a, r[i]);
      end
      if (p[0][1]) begin
        check(we_cnt == we0 + 1 && re_cnt == re0, {tag, " R5 one write strobe"}, we_cnt - we0, 1);
        check(we_addr == p[1] && we_data == p[5], {tag, " R5 write addr/data"},
              {we_addr, we_data}, {p[1], p[5]});
      end else begin
        check(re_cnt == re0 + 1 && we_cnt == we0, {tag, " R6 one read strobe"}, re_cnt - re0, 1);
      end
    end else begin
      repeat (20) @(negedge clk);
      check(rsp_q.size() == 0 && we_cnt == we0 && re_cnt == re0,
            {tag, " R2/R3/R4 dropped silently"}, rsp_q.size() + we_cnt - we0 + re_cnt - re0, 0);
      rsp_q.delete();
    end
  endtask

  function automatic logic [7:0] hdr_of(input logic [2:0] typ, input logic [2:0] dev,
                                        input logic [1:0] op);
    return {typ, dev, op};
  endfunction

  initial begin
    logic [6:0][7:0] p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rx_ready_o == 1'b1, "R11 rx_ready_o", rx_ready_o, 1);
    check(tx_valid_o == 1'b0 && reg_we_o == 1'b0 && reg_re_o == 1'b0, "R11 outputs idle",
          {tx_valid_o, reg_we_o, reg_re_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: R1 write then read back, R5 R6
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b11), 8'h3c, 8'ha5, 0); run_cmd(p, 1, -1, 0, "R1 write");
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b01), 8'h3c, 8'h00, 0); run_cmd(p, 1, -1, 0, "R6 readback");
    // R4 illegal ops
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b00), 8'h10, 8'h11, 0); run_cmd(p, 0, -1, 0, "R4 op00");
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b10), 8'h10, 8'h11, 0); run_cmd(p, 0, -1, 0, "R4 op10");
    // R3 foreign device / type
    p = mk_pkt(hdr_of(3'b010, 3'd4, 2'b11), 8'h10, 8'h11, 0); run_cmd(p, 0, -1, 0, "R3 dev");
    p = mk_pkt(hdr_of(3'b011, DEV, 2'b11), 8'h10, 8'h11, 0); run_cmd(p, 0, -1, 0, "R3 type");
    // R2 bad checksum
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b11), 8'h10, 8'h11, 1); run_cmd(p, 0, -1, 0, "R2 sum");
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b01), 8'h10, 8'h00, 0); run_cmd(p, 1, -1, 0, "R2 reg untouched");

    // R10 gap of GAP-1 keeps the frame
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b11), 8'h55, 8'h77, 0); run_cmd(p, 1, 3, GAP - 1, "R10 gap kept");
    // R10 gap of GAP drops the prefix, a fresh frame follows
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b11), 8'h56, 8'h99, 0);
    for (int i = 0; i < 3; i++) send_byte(p[i]);
    repeat (GAP) @(posedge clk);
    p = mk_pkt(hdr_of(3'b010, DEV, 2'b01), 8'h56, 8'h00, 0); run_cmd(p, 1, -1, 0, "R10 gap resync");

    // R8 random traffic under back-pressure
    rand_rdy = 1'b1;
    for (int n = 0; n < 60; n++) begin
      int kind;
      logic [7:0] a;
      kind = $urandom % 10;
      a = 8'($urandom % 16);
      case (kind)
        0: begin p = mk_pkt(hdr_of(3'b010, DEV ^ 3'd1, 2'b01), a, 8'h00, 0); run_cmd(p, 0, -1, 0, "R3 rand"); end
        1: begin p = mk_pkt(hdr_of(3'b010, DEV, 2'b01), a, 8'h00, 1); run_cmd(p, 0, -1, 0, "R2 rand"); end
        2, 3, 4, 5: begin p = mk_pkt(hdr_of(3'b010, DEV, 2'b11), a, 8'($urandom), 0); run_cmd(p, 1, -1, 0, "R8 rand wr"); end
        default: begin p = mk_pkt(hdr_of(3'b010, DEV, 2'b01), a, 8'h00, 0); run_cmd(p, 1, -1, 0, "R8 rand rd"); end
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule